// File: doc/BRIEF.md
# Fixed-point to single-precision converter

The block turns a scaled two's-complement word into a binary32 floating-point value. The input word is `W` bits wide and its binary point sits `F` bits above the least significant bit, so the number it stands for is the signed integer read from the word times 2^-F. Both widths are fixed when the block is elaborated. With `F = 0` and `W = 32` the input is a plain signed 32-bit integer.

The converter is a three-stage pipeline on one clock. A conversion is launched in every cycle where new-data, ready-for-data and clock enable are all high. Its result appears, with result-ready high, three enabled clock edges later. Taking the magnitude, normalising it and rounding it each take one stage. When the input has more significant bits than the 24-bit significand can hold, the surplus is rounded to nearest, with ties going to the even value. A synchronous control reset empties the pipeline of pending results, and it takes priority over the clock enable.

Top module: `fixed_to_float`

## Requirements
- R1: An accepted input `a_i` yields `result_o` equal to the value int(a_i)·2^-F in binary32 layout: sign in bit 31, exponent biased by 127 in bits 30:23, fraction without its hidden bit in bits 22:0. Example: for W=32, F=4, raw 0x00000010 gives 0x3F800000.
- R2: A zero input gives +0 (0x00000000), never -0.
- R3: The most negative input converts exactly to sign 1, exponent 127+W-1-F and fraction 0. Example: for W=32, F=4 it gives 0xCD000000.
- R4: When the magnitude has more than 24 significant bits, the bits below the significand are rounded to nearest, with ties to even.
- R5: When rounding carries out of the significand, the exponent rises by one and the fraction becomes 0. Example: for W=32, F=4, raw 0x01FFFFFF gives 0x4A000000.
- R6: A conversion starts only on a rising edge where `nd_i`, `rfd_o` and `ce_i` are all high. `rdy_o` is high exactly for the cycle that follows the third enabled edge after the start, and one conversion can start on every cycle.
- R7: While `ce_i` is low and `sclr_i` is low, `rdy_o`, `rfd_o` and `result_o` hold their values and no conversion starts or advances.
- R8: An edge with `sclr_i` high, whatever `ce_i` is, forces `rfd_o` and `rdy_o` low and discards every result still in flight. `rfd_o` rises on the first enabled edge after `sclr_i` falls.
- R9: A result never has an all-ones or all-zero exponent unless it is +0. Elaboration fails when F > W-1, W < 2 or W > 32.
- R10: While `rst_ni` is low, `rfd_o` and `rdy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclr_i | input | 1 | Synchronous control reset; takes priority over ce_i |
| ce_i | input | 1 | Clock enable |
| nd_i | input | 1 | New data: a_i is valid |
| a_i | input | W | Two's-complement fixed-point operand, F fraction bits |
| rfd_o | output | 1 | Ready for data |
| rdy_o | output | 1 | result_o is valid |
| result_o | output | 32 | Converted binary32 value |

## Verification
The hardest cases to reach are a rounding tie and a rounding carry-out in a result that lands while the clock enable is stalling the pipeline, and a control reset that arrives with ce_i low while conversions are in flight. The stimulus places exact tie patterns (2^24 + 1 and 2^24 + 3), all-ones 25-bit magnitudes and the most negative word among back-to-back inputs. It then runs a long stretch in which ce_i, nd_i and the operand shapes are all randomised, and asserts sclr_i both with the enable high and with it low in the middle of a burst. A behavioural model is compared against the outputs on every cycle.

// File: rtl/fx2fp_pkg.sv
package fx2fp_pkg;
  localparam int SIG_W    = 24;
  localparam int FRAC_W   = 23;
  localparam int EXP_W    = 8;
  localparam int EXP_BIAS = 127;
  localparam int FP_W     = 1 + EXP_W + FRAC_W;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0] frac;
  } fp32_t;
endpackage

// File: rtl/fx2fp_ctrl.sv
module fx2fp_ctrl #(
  parameter int STAGES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclr_i,
  input  logic              ce_i,
  input  logic              nd_i,
  output logic              rfd_o,
  output logic              take_o,
  output logic [STAGES-1:0] vld_o
);
  logic rfd_q;
  assign rfd_o  = rfd_q;
  assign take_o = nd_i & rfd_q & ce_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rfd_q <= 1'b0;
    else if (sclr_i) rfd_q <= 1'b0;
    else if (ce_i)   rfd_q <= 1'b1;
  end

  for (genvar i = 0; i < STAGES; i++) begin : g_vld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     vld_o[i] <= 1'b0;
      else if (sclr_i) vld_o[i] <= 1'b0;
      else if (ce_i)   vld_o[i] <= (i == 0) ? take_o : vld_o[(i == 0) ? 0 : i-1];
    end
  end

  // R8
  sclr_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclr_i |=> (!rfd_o && vld_o == '0));
  // R6
  no_take_without_rfd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rfd_o && ce_i && !sclr_i) |=> !vld_o[0]);
endmodule

// File: rtl/fx2fp_lod.sv
module fx2fp_lod #(
  parameter int W  = 32,
  localparam int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  mag_i,
  output logic [PW-1:0] pos_o
);
  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++)
      if (mag_i[i]) pos_o = PW'(i);
  end
endmodule

// File: rtl/fx2fp_round.sv
module fx2fp_round
  import fx2fp_pkg::*;
#(
  parameter int EW = 32
) (
  input  logic [EW-1:0]     norm_i,
  input  logic [EXP_W-1:0]  exp_i,
  output logic [EXP_W-1:0]  exp_o,
  output logic [FRAC_W-1:0] frac_o
);
  logic [SIG_W-1:0] sig;
  logic             guard, sticky, up;
  logic [SIG_W:0]   sum;

  assign sig    = norm_i[EW-1 -: SIG_W];
  assign guard  = norm_i[EW-SIG_W-1];
  assign sticky = |norm_i[EW-SIG_W-2:0];
  assign up     = guard & (sticky | sig[0]);
  assign sum    = {1'b0, sig} + {{SIG_W{1'b0}}, up};

  always_comb begin
    if (sum[SIG_W]) begin
      exp_o  = exp_i + EXP_W'(1);
      frac_o = '0;
    end else begin
      exp_o  = exp_i;
      frac_o = sum[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/fixed_to_float.sv
module fixed_to_float
  import fx2fp_pkg::*;
#(
  parameter int W = 32,
  parameter int F = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sclr_i,
  input  logic            ce_i,
  input  logic            nd_i,
  input  logic [W-1:0]    a_i,
  output logic            rfd_o,
  output logic            rdy_o,
  output logic [FP_W-1:0] result_o
);
  localparam int EW  = (W < SIG_W + 2) ? SIG_W + 2 : W;
  localparam int PW  = (W > 1) ? $clog2(W) : 1;
  localparam int SHW = $clog2(EW) + 1;

  if (F > W - 1 || W < 2 || W > 32) begin : g_bad_cfg
    $error("fixed_to_float: unsupported W/F");
  end

  logic       take;
  logic [2:0] vld;

  fx2fp_ctrl #(.STAGES(3)) u_ctrl (
    .clk_i, .rst_ni, .sclr_i, .ce_i, .nd_i,
    .rfd_o, .take_o(take), .vld_o(vld)
  );
  assign rdy_o = vld[2];

  // stage 1: sign and magnitude
  logic         s1_sign, s1_zero;
  logic [W-1:0] s1_mag;
  always_ff @(posedge clk_i) begin
    if (ce_i) begin
      s1_sign <= a_i[W-1];
      s1_zero <= (a_i == '0);
      s1_mag  <= a_i[W-1] ? (~a_i + W'(1)) : a_i;
    end
  end

  // stage 2: normalise
  logic [PW-1:0]    pos;
  logic [SHW-1:0]   sh;
  logic [EW-1:0]    norm;
  logic [EXP_W-1:0] exp_pre;

  fx2fp_lod #(.W(W)) u_lod (.mag_i(s1_mag), .pos_o(pos));

  assign sh      = SHW'(EW - 1) - SHW'(pos);
  assign norm    = EW'(s1_mag) << sh;
  assign exp_pre = EXP_W'(EXP_BIAS - F) + EXP_W'(pos);

  logic             s2_sign, s2_zero;
  logic [EW-1:0]    s2_norm;
  logic [EXP_W-1:0] s2_exp;
  always_ff @(posedge clk_i) begin
    if (ce_i) begin
      s2_sign <= s1_sign;
      s2_zero <= s1_zero;
      s2_norm <= norm;
      s2_exp  <= exp_pre;
    end
  end

  // stage 3: round and pack
  logic [EXP_W-1:0]  exp_r;
  logic [FRAC_W-1:0] frac_r;
  fx2fp_round #(.EW(EW)) u_round (
    .norm_i(s2_norm), .exp_i(s2_exp), .exp_o(exp_r), .frac_o(frac_r)
  );

  fp32_t s3_res;
  always_ff @(posedge clk_i) begin
    if (ce_i) s3_res <= s2_zero ? '0 : fp32_t'{s2_sign, exp_r, frac_r};
  end
  assign result_o = s3_res;

  // R9
  no_special_exp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> (result_o[30:23] != 8'hFF &&
               (result_o[30:23] != 8'h00 || result_o == '0)));
  // R2
  unsigned_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && result_o[30:0] == '0) |-> !result_o[31]);
  // R7
  ce_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sclr_i && !ce_i) |=> ($stable(rdy_o) && $stable(rfd_o) && $stable(result_o)));
endmodule

// File: tb/fixed_to_float_tb_top.sv
module fixed_to_float_tb_top;
  localparam int W = 32;
  localparam int F = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sclr = 1'b0, ce = 1'b0, nd = 1'b0;
  logic [W-1:0]  a = '0;
  logic          rfd, rdy;
  logic [31:0]   res;

  always #2 clk = ~clk;

  fixed_to_float #(.W(W), .F(F)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclr_i(sclr), .ce_i(ce), .nd_i(nd),
    .a_i(a), .rfd_o(rfd), .rdy_o(rdy), .result_o(res)
  );

  int    n_run = 0, n_fail = 0;
  bit    done = 0;
  string cur_tag = "R1";

  function automatic logic [31:0] ref_cvt(logic [W-1:0] x);
    longint v, m, q, rem, half;
    int msb, e, s;
    logic sg;
    v  = longint'($signed(x));
    sg = (v < 0);
    m  = sg ? -v : v;
    if (m == 0) return 32'h0;
    msb = 0;
    for (int i = 0; i < 63; i++) if ((m >> i) & 1) msb = i;
    e = 127 + msb - F;
    if (msb > 23) begin
      s = msb - 23;
      q = m >> s;
      rem = m - (q << s);
      half = longint'(1) << (s - 1);
      if (rem > half || (rem == half && q[0])) q++;
      if (q == (longint'(1) << 24)) begin q = q >> 1; e++; end
    end else q = m << (23 - msb);
    return {sg, e[7:0], q[22:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // cycle model
  bit          m_rfd;
  bit          m_v[3];
  logic [31:0] m_d[3];
  string       m_t[3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rfd = 0;
      for (int i = 0; i < 3; i++) m_v[i] = 0;
    end else if (sclr) begin
      m_rfd = 0;
      for (int i = 0; i < 3; i++) m_v[i] = 0;
    end else if (ce) begin
      m_v[2] = m_v[1]; m_d[2] = m_d[1]; m_t[2] = m_t[1];
      m_v[1] = m_v[0]; m_d[1] = m_d[0]; m_t[1] = m_t[0];
      m_v[0] = nd && m_rfd;
      m_d[0] = ref_cvt(a);
      m_t[0] = cur_tag;
      m_rfd  = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R8 rfd", {31'b0, rfd}, {31'b0, m_rfd});
      check("R6 rdy", {31'b0, rdy}, {31'b0, m_v[2]});
      if (m_v[2] && rdy) check(m_t[2], res, m_d[2]);
    end
  end

  task automatic drive(bit n, logic [W-1:0] x, bit c, bit s, string tag);
    nd = n; a = x; ce = c; sclr = s; cur_tag = tag;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10 rfd", {31'b0, rfd}, 32'h0);
    check("R10 rdy", {31'b0, rdy}, 32'h0);
    // reference sanity on stated examples
    check("R1 ref", ref_cvt(32'h10), 32'h3F800000);
    check("R3 ref", ref_cvt(32'h80000000), 32'hCD000000);
    check("R5 ref", ref_cvt(32'h01FFFFFF), 32'h4A000000);
    check("R2 ref", ref_cvt(32'h0), 32'h0);
    rst_n = 1;
    drive(0, '0, 1, 0, "R8");
    drive(0, '0, 1, 0, "R8");
    // back-to-back directed
    drive(1, 32'h00000010, 1, 0, "R1");
    drive(1, 32'hFFFFFFF0, 1, 0, "R1");
    drive(1, 32'h00000001, 1, 0, "R1");
    drive(1, 32'h0,        1, 0, "R2");
    drive(1, 32'h80000000, 1, 0, "R3");
    drive(1, 32'h7FFFFFFF, 1, 0, "R5");
    drive(1, 32'h01000001, 1, 0, "R4");
    drive(1, 32'h01000003, 1, 0, "R4");
    drive(1, 32'hFEFFFFFF, 1, 0, "R4");
    drive(1, 32'h01FFFFFF, 1, 0, "R5");
    drive(1, 32'hFE000001, 1, 0, "R5");
    repeat (4) drive(0, 32'h12345678, 1, 0, "R6");
    // stall mid-burst
    drive(1, 32'h01000001, 1, 0, "R7");
    drive(1, 32'h01FFFFFF, 1, 0, "R7");
    repeat (3) drive(1, 32'h55555555, 0, 0, "R7");
    drive(1, 32'h80000000, 1, 0, "R7");
    repeat (5) drive(0, 32'h0, 1, 0, "R7");
    // control reset in flight, enable high then low
    drive(1, 32'h00ABCDEF, 1, 0, "R8");
    drive(1, 32'h00001234, 1, 0, "R8");
    drive(1, 32'hDEADBEEF, 1, 1, "R8");
    drive(1, 32'hDEADBEEF, 1, 1, "R8");
    drive(1, 32'h00000100, 1, 0, "R8");
    drive(1, 32'h00000200, 1, 0, "R8");
    drive(1, 32'h00000300, 1, 0, "R8");
    drive(1, 32'h00000400, 0, 1, "R8");
    drive(0, 32'h0, 0, 0, "R8");
    drive(1, 32'h00000500, 1, 0, "R8");
    drive(1, 32'h00000600, 1, 0, "R8");
    repeat (5) drive(0, 32'h0, 1, 0, "R8");
    // random shapes, enable and occasional control reset
    for (int k = 0; k < 4000; k++) begin
      logic [W-1:0] x;
      int sel;
      sel = $urandom % 5;
      x = $urandom;
      case (sel)
        0: x = x >> ($urandom % 32);
        1: x = {x[31:7], 7'b1000000};
        2: x = 32'h01000000 | (x & 32'h00FFFFFF) | 32'h1;
        3: x = 32'h80000000 | (x & 32'h1);
        default: ;
      endcase
      drive(($urandom % 4) != 0, x, ($urandom % 3) != 0,
            ($urandom % 200) == 0, "R4");
    end
    repeat (6) drive(0, 32'h0, 1, 0, "R6");
    finish_run();
  end
endmodule